// File: doc/BRIEF.md
# SIMT warp execution pipeline

This block is the execution back end of a small SIMT processor. Each instruction it accepts applies to every thread of one warp: the issue port names the warp, a two-bit opcode, a destination register and two source registers. The block reads the first source for all lanes of that warp in the cycle of acceptance and the second source in the following cycle. Both are parked in a per-warp operand collector. Once both are present, the warp competes for a processing-element array that is narrower than the warp. The warp then runs as a series of lane groups over consecutive cycles, and each group's results go out on a writeback port and into the register file.

Two warp slots can be in flight at once, one per warp, each with its own instruction. The register file is banked per warp, with one read port per bank and a single shared write port. A write that coincides with a read of the same word is bypassed to the reader. The processing-element count is a parameter: 16 lanes give two beats per 32-thread warp, and 8 lanes give four.

Top module: `simt_warp_pipe`

## Requirements
- R1: After reset, iss_ready is high for every warp and wb_valid and done are low. Every register word of warp w, register r, lane l holds (w*0x01000000 + r*0x1F000A31 + l*0x00031005 + 0x80000001) mod 2^32.
- R2: Opcode 2'b00 gives a+b, 2'b01 gives a-b, 2'b10 gives a AND b, and 2'b11 gives a OR b. Each is computed per lane modulo 2^32, where a is the first source and b the second, both from the issuing warp's bank.
- R3: A result leaves in C = WARP_SIZE/NUM_PE beats in ascending lane order. Beat k carries lanes k*NUM_PE upward, with wb_lane_base = k*NUM_PE, and lane i of the group in wb_data bits [32i+31:32i]. Each beat carries the destination on wb_reg and the warp on wb_warp, and every written lane is later read back with the new value.
- R4: For an instruction accepted in cycle T with the processing elements free, beats appear in cycles T+3 to T+2+C. done, with done_warp, is high exactly in the cycle of the last beat.
- R5: iss_ready for a warp is low from the cycle after acceptance until its last beat. It is high again in the cycle of that last beat. The other warp can be accepted in the meantime.
- R6: A warp that starts executing keeps the processing elements for all of its beats, with no interleaving. A warp that becomes ready in the meantime, even the lower-numbered one, finishes exactly C cycles after the holder's last beat. When both are ready in the same free cycle, slot 0 goes first.
- R7: An instruction accepted in the cycle of the previous instruction's last beat for the same warp reads the values that beat writes.
- R8: Writes to one warp's bank leave the other warp's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | The slot of the warp on iss_warp can accept |
| iss_warp | input | 1 | Warp slot of the instruction |
| iss_op | input | 2 | Opcode (R2) |
| iss_dst | input | 3 | Destination register |
| iss_src_a | input | 3 | First source register |
| iss_src_b | input | 3 | Second source register |
| wb_valid | output | 1 | Writeback beat present |
| wb_warp | output | 1 | Warp of the beat |
| wb_reg | output | 3 | Destination register of the beat |
| wb_lane_base | output | 5 | First lane of the beat |
| wb_data | output | 512 | NUM_PE results, lane group packed low first |
| done | output | 1 | Last beat of an instruction |
| done_warp | output | 1 | Warp whose instruction completed |

## Verification
The bench goes after the bypass case. It issues a dependent instruction in the very cycle the producer's final beat lands. A design without the bypass returns stale values in the upper lane group only, so lanes 0-15 still look correct. It also overlaps two warps in both orders. A design that pre-empts, or that lets the lower slot cut in, shows up as an interleaved beat sequence or as a finish time other than C cycles after the holder's. Wrap-around sums and differences in the sweep expose an adder or subtractor that saturates or swaps operands. Reading the same register number from both banks after a write exposes any mixing between the banks.

// File: rtl/simt_pkg.sv
package simt_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_FETCH_B,
        SL_WAIT,
        SL_EXEC,
        SL_DRAIN
    } slot_st_e;

    function automatic word_t lane_alu(op_e op, word_t a, word_t b);
        word_t r;
        case (op)
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_AND:  r = a & b;
            default: r = a | b;
        endcase
        return r;
    endfunction

    function automatic word_t seed_word(int unsigned w, int unsigned r, int unsigned l);
        return 32'(w) * 32'h0100_0000 + 32'(r) * 32'h1F00_0A31
             + 32'(l) * 32'h0003_1005 + 32'h8000_0001;
    endfunction
endpackage

// File: rtl/simt_regfile.sv
module simt_regfile import simt_pkg::*; #(
    parameter int unsigned NUM_WARPS = 2,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned WARP_SIZE = 32,
    parameter int unsigned NUM_PE    = 16,
    localparam int unsigned WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int unsigned REG_W  = $clog2(NUM_REGS),
    localparam int unsigned CH_W   = $clog2(WARP_SIZE / NUM_PE)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [NUM_WARPS-1:0][REG_W-1:0]        rd_reg,
    output word_t [NUM_WARPS-1:0][WARP_SIZE-1:0]   rd_data,
    input  logic                                   wr_en,
    input  logic [WARP_W-1:0]                      wr_warp,
    input  logic [REG_W-1:0]                       wr_reg,
    input  logic [CH_W-1:0]                        wr_chunk,
    input  word_t [NUM_PE-1:0]                     wr_data
);
    word_t mem [NUM_WARPS][NUM_REGS][WARP_SIZE];

    // One write port: a lane group of one register of one warp per cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < int'(NUM_WARPS); w++)
                for (int r = 0; r < int'(NUM_REGS); r++)
                    for (int l = 0; l < int'(WARP_SIZE); l++)
                        mem[w][r][l] <= seed_word(w, r, l);
        end else if (wr_en) begin
            for (int l = 0; l < int'(WARP_SIZE); l++)
                if (CH_W'(l / int'(NUM_PE)) == wr_chunk)
                    mem[wr_warp][wr_reg][l] <= wr_data[l % int'(NUM_PE)];
        end
    end

    // One full-warp read port per bank, with write-to-read bypass.
    always_comb begin
        for (int w = 0; w < int'(NUM_WARPS); w++)
            for (int l = 0; l < int'(WARP_SIZE); l++) begin
                rd_data[w][l] = mem[w][rd_reg[w]][l];
                if (wr_en && wr_warp == WARP_W'(w) && wr_reg == rd_reg[w]
                    && wr_chunk == CH_W'(l / int'(NUM_PE)))
                    rd_data[w][l] = wr_data[l % int'(NUM_PE)];
            end
    end
endmodule

// File: rtl/simt_collector.sv
module simt_collector import simt_pkg::*; #(
    parameter int unsigned WARP_SIZE = 32,
    parameter int unsigned REG_W     = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          accept,
    input  logic [1:0]                    in_op,
    input  logic [REG_W-1:0]              in_dst,
    input  logic [REG_W-1:0]              in_src_a,
    input  logic [REG_W-1:0]              in_src_b,
    input  word_t [WARP_SIZE-1:0]         rd_data,
    input  logic                          grant,
    input  logic                          finish,
    output logic [REG_W-1:0]              rd_reg,
    output logic                          free,
    output logic                          ready,
    output logic                          executing,
    output word_t [WARP_SIZE-1:0]         opd_a,
    output word_t [WARP_SIZE-1:0]         opd_b,
    output logic [1:0]                    opc,
    output logic [REG_W-1:0]              dst
);
    slot_st_e         st;
    logic [REG_W-1:0] src_b_q;

    assign free      = (st == SL_IDLE) || (st == SL_DRAIN);
    assign ready     = (st == SL_WAIT);
    assign executing = (st == SL_EXEC);
    // First source is read in the accept cycle, the second one cycle later.
    assign rd_reg    = (st == SL_FETCH_B) ? src_b_q : in_src_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SL_IDLE;
        end else begin
            case (st)
                SL_IDLE, SL_DRAIN: st <= accept ? SL_FETCH_B : SL_IDLE;
                SL_FETCH_B:        st <= SL_WAIT;
                SL_WAIT:           if (grant)  st <= SL_EXEC;
                SL_EXEC:           if (finish) st <= SL_DRAIN;
                default:           st <= SL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (free && accept) begin
            opd_a   <= rd_data;
            opc     <= in_op;
            dst     <= in_dst;
            src_b_q <= in_src_b;
        end
        if (st == SL_FETCH_B)
            opd_b <= rd_data;
    end
endmodule

// File: rtl/simt_exec.sv
module simt_exec import simt_pkg::*; #(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned WARP_SIZE = 32,
    parameter int unsigned NUM_PE    = 16,
    parameter int unsigned REG_W     = 3,
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned CHUNKS = WARP_SIZE / NUM_PE,
    localparam int unsigned CH_W   = $clog2(CHUNKS),
    localparam int unsigned PE_W   = $clog2(NUM_PE),
    localparam int unsigned LANE_W = $clog2(WARP_SIZE)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_SLOTS-1:0]                  rdy_vec,
    input  word_t [NUM_SLOTS-1:0][WARP_SIZE-1:0]  opd_a,
    input  word_t [NUM_SLOTS-1:0][WARP_SIZE-1:0]  opd_b,
    input  logic [NUM_SLOTS-1:0][1:0]             opc,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0]       dst,
    output logic [NUM_SLOTS-1:0]                  grant_vec,
    output logic [NUM_SLOTS-1:0]                  finish_vec,
    output logic                                  wb_valid,
    output logic [SLOT_W-1:0]                     wb_slot,
    output logic [REG_W-1:0]                      wb_reg,
    output logic [CH_W-1:0]                       wb_chunk,
    output word_t [NUM_PE-1:0]                    wb_data,
    output logic                                  wb_last
);
    logic              own_busy;
    logic [SLOT_W-1:0] own_slot;
    logic [CH_W-1:0]   own_ch;
    logic              active, last;
    logic [SLOT_W-1:0] sel;
    logic [CH_W-1:0]   cur_ch;
    word_t [NUM_PE-1:0] alu_out;

    // Non-preemptive owner; a free array goes to the lowest ready slot.
    always_comb begin
        active    = 1'b0;
        sel       = '0;
        cur_ch    = '0;
        grant_vec = '0;
        if (own_busy) begin
            active = 1'b1;
            sel    = own_slot;
            cur_ch = own_ch;
        end else begin
            for (int s = 0; s < int'(NUM_SLOTS); s++)
                if (!active && rdy_vec[s]) begin
                    active       = 1'b1;
                    sel          = SLOT_W'(s);
                    grant_vec[s] = 1'b1;
                end
        end
        last       = active && (cur_ch == CH_W'(CHUNKS - 1));
        finish_vec = '0;
        if (last) finish_vec[sel] = 1'b1;
    end

    for (genvar i = 0; i < int'(NUM_PE); i++) begin : g_pe
        logic [LANE_W-1:0] lane;
        assign lane       = {cur_ch, PE_W'(i)};
        assign alu_out[i] = lane_alu(op_e'(opc[sel]), opd_a[sel][lane], opd_b[sel][lane]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_busy <= 1'b0;
            own_slot <= '0;
            own_ch   <= '0;
            wb_valid <= 1'b0;
            wb_last  <= 1'b0;
        end else begin
            if (last) begin
                own_busy <= 1'b0;
            end else if (active) begin
                own_busy <= 1'b1;
                own_slot <= sel;
                own_ch   <= cur_ch + CH_W'(1);
            end
            wb_valid <= active;
            wb_last  <= last;
        end
    end

    always_ff @(posedge clk) begin
        wb_slot  <= sel;
        wb_reg   <= dst[sel];
        wb_chunk <= cur_ch;
        wb_data  <= alu_out;
    end

    // R3: beats of one instruction are back to back and ascend by one lane group
    a_r3_beats_ascend: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_last) |=> (wb_valid && wb_slot == $past(wb_slot)
                                    && wb_chunk == $past(wb_chunk) + CH_W'(1)));
endmodule

// File: rtl/simt_warp_pipe.sv
module simt_warp_pipe import simt_pkg::*; #(
    parameter int unsigned NUM_WARPS = 2,
    parameter int unsigned WARP_SIZE = 32,
    parameter int unsigned NUM_PE    = 16,
    parameter int unsigned NUM_REGS  = 8,
    localparam int unsigned WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int unsigned REG_W  = $clog2(NUM_REGS),
    localparam int unsigned LANE_W = $clog2(WARP_SIZE),
    localparam int unsigned CH_W   = $clog2(WARP_SIZE / NUM_PE),
    localparam int unsigned PE_W   = $clog2(NUM_PE)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_valid,
    output logic                       iss_ready,
    input  logic [WARP_W-1:0]          iss_warp,
    input  logic [1:0]                 iss_op,
    input  logic [REG_W-1:0]           iss_dst,
    input  logic [REG_W-1:0]           iss_src_a,
    input  logic [REG_W-1:0]           iss_src_b,
    output logic                       wb_valid,
    output logic [WARP_W-1:0]          wb_warp,
    output logic [REG_W-1:0]           wb_reg,
    output logic [LANE_W-1:0]          wb_lane_base,
    output logic [NUM_PE*WORD_W-1:0]   wb_data,
    output logic                       done,
    output logic                       done_warp
);
    logic [NUM_WARPS-1:0]                 free_vec, rdy_vec, exec_vec;
    logic [NUM_WARPS-1:0]                 accept_vec, grant_vec, finish_vec;
    logic [NUM_WARPS-1:0][REG_W-1:0]      rf_rd_reg, slot_dst;
    logic [NUM_WARPS-1:0][1:0]            slot_opc;
    word_t [NUM_WARPS-1:0][WARP_SIZE-1:0] rf_rd_data, opd_a, opd_b;
    logic [CH_W-1:0]                      wb_chunk;
    logic                                 wb_last;
    word_t [NUM_PE-1:0]                   wb_lanes;

    assign iss_ready = free_vec[iss_warp];

    for (genvar s = 0; s < int'(NUM_WARPS); s++) begin : g_slot
        assign accept_vec[s] = iss_valid && iss_ready && (iss_warp == WARP_W'(s));
        simt_collector #(.WARP_SIZE(WARP_SIZE), .REG_W(REG_W)) i_coll (
            .clk(clk), .rst(rst), .accept(accept_vec[s]),
            .in_op(iss_op), .in_dst(iss_dst), .in_src_a(iss_src_a), .in_src_b(iss_src_b),
            .rd_data(rf_rd_data[s]), .grant(grant_vec[s]), .finish(finish_vec[s]),
            .rd_reg(rf_rd_reg[s]), .free(free_vec[s]), .ready(rdy_vec[s]),
            .executing(exec_vec[s]), .opd_a(opd_a[s]), .opd_b(opd_b[s]),
            .opc(slot_opc[s]), .dst(slot_dst[s])
        );
    end

    simt_exec #(.NUM_SLOTS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .NUM_PE(NUM_PE),
                .REG_W(REG_W)) i_exec (
        .clk(clk), .rst(rst), .rdy_vec(rdy_vec), .opd_a(opd_a), .opd_b(opd_b),
        .opc(slot_opc), .dst(slot_dst), .grant_vec(grant_vec), .finish_vec(finish_vec),
        .wb_valid(wb_valid), .wb_slot(wb_warp), .wb_reg(wb_reg), .wb_chunk(wb_chunk),
        .wb_data(wb_lanes), .wb_last(wb_last)
    );

    simt_regfile #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .WARP_SIZE(WARP_SIZE),
                   .NUM_PE(NUM_PE)) i_rf (
        .clk(clk), .rst(rst), .rd_reg(rf_rd_reg), .rd_data(rf_rd_data),
        .wr_en(wb_valid), .wr_warp(wb_warp), .wr_reg(wb_reg), .wr_chunk(wb_chunk),
        .wr_data(wb_lanes)
    );

    assign wb_lane_base = {wb_chunk, {PE_W{1'b0}}};
    assign wb_data      = wb_lanes;
    assign done         = wb_valid && wb_last;
    assign done_warp    = wb_warp[0];

    // R5: an accepted warp's slot is occupied in the following cycle
    a_r5_slot_held: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> !free_vec[$past(iss_warp)]);

    // R4: completion coincides with the highest lane group
    a_r4_done_on_last_group: assert property (@(posedge clk) disable iff (rst)
        done |-> (wb_valid && wb_lane_base == LANE_W'(WARP_SIZE - NUM_PE)));

    // R6: at most one warp occupies the processing elements
    a_r6_single_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(exec_vec));

    // R6: an executing warp is never joined by a fresh grant
    a_r6_no_grant_while_owned: assert property (@(posedge clk) disable iff (rst)
        (exec_vec != '0) |-> (grant_vec == '0));
endmodule

// File: tb/test_simt_warp_pipe.sv
module test_simt_warp_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 2;
    localparam int WS = 32;
    localparam int PE = 16;
    localparam int NR = 8;
    localparam int C  = WS / PE;

    logic clk = 1'b0, rst = 1'b1;
    logic iss_valid = 1'b0, iss_ready;
    logic iss_warp = 1'b0;
    logic [1:0] iss_op = 2'b00;
    logic [2:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic wb_valid, done, done_warp;
    logic wb_warp;
    logic [2:0] wb_reg;
    logic [4:0] wb_lane_base;
    logic [PE*32-1:0] wb_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    simt_warp_pipe #(.NUM_WARPS(NW), .WARP_SIZE(WS), .NUM_PE(PE), .NUM_REGS(NR)) i_simt_warp_pipe (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_warp(iss_warp), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .wb_valid(wb_valid),
        .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_lane_base(wb_lane_base),
        .wb_data(wb_data), .done(done), .done_warp(done_warp)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    logic [31:0] mdl [NW][NR][WS];
    logic [31:0] exp_res [NW][WS];
    int exp_dst [NW], beat [NW], acc [NW], lat [NW];
    bit pend [NW];
    string tag [NW];
    bit pv = 0;
    int pw = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_m(int w, int r, int l);
        return 32'(w) * 32'h0100_0000 + 32'(r) * 32'h1F00_0A31 + 32'(l) * 32'h0003_1005 + 32'h8000_0001;
    endfunction

    function automatic logic [31:0] ref_alu(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            default: return a | b;
        endcase
    endfunction

    // Writeback monitor: checks every beat against the model and updates it.
    always @(negedge clk) begin
        int w, bad;
        if (!rst && !finished) begin
            if (wb_valid) begin
                w = int'(wb_warp);
                chk(pend[w], {tag[w], " R3 beat for an issued warp"}, 32'(w), 32'(w));
                chk(wb_reg == 3'(exp_dst[w]), {tag[w], " R3 wb_reg"}, 32'(wb_reg), 32'(exp_dst[w]));
                chk(wb_lane_base == 5'(beat[w] * PE), {tag[w], " R3 lane base"},
                    32'(wb_lane_base), 32'(beat[w] * PE));
                if (wb_lane_base != 0)
                    chk(pv && pw == w, {tag[w], " R6 beats not interleaved"}, 32'(pw), 32'(w));
                bad = -1;
                for (int i = 0; i < PE; i++)
                    if (wb_data[i*32 +: 32] !== exp_res[w][(beat[w]*PE + i) % WS]) bad = i;
                if (bad >= 0)
                    chk(0, {tag[w], " data"}, wb_data[bad*32 +: 32], exp_res[w][(beat[w]*PE + bad) % WS]);
                else
                    chk(1, {tag[w], " data"}, 0, 0);
                for (int i = 0; i < PE; i++)
                    mdl[w][exp_dst[w]][(beat[w]*PE + i) % WS] = wb_data[i*32 +: 32];
                beat[w]++;
                chk(done == (beat[w] == C), {tag[w], " R4 done on last beat only"}, 32'(done), 32'(beat[w] == C));
                if (beat[w] >= C) begin
                    chk(done_warp == w[0], {tag[w], " R4 done_warp"}, 32'(done_warp), 32'(w));
                    if (lat[w] > 0)
                        chk(cyc - acc[w] == lat[w], {tag[w], " R4 completion cycle"},
                            32'(cyc - acc[w]), 32'(lat[w]));
                    pend[w] = 0;
                    beat[w] = 0;
                end
                pv = 1;
                pw = w;
            end else begin
                pv = 0;
            end
        end
    end

    task automatic issue(int w, int op, int d, int a, int b, int lt, string tg);
        iss_warp = w[0]; iss_op = 2'(op); iss_dst = 3'(d);
        iss_src_a = 3'(a); iss_src_b = 3'(b); iss_valid = 1'b1;
        #1;
        while (!iss_ready) begin
            @(negedge clk);
            #1;
        end
        acc[w] = cyc;
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        for (int l = 0; l < WS; l++) exp_res[w][l] = ref_alu(op, mdl[w][a][l], mdl[w][b][l]);
        exp_dst[w] = d; beat[w] = 0; pend[w] = 1; lat[w] = lt; tag[w] = tg;
        chk(!iss_ready, {tg, " R5 ready low after accept"}, 32'(iss_ready), 0);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (pend[0] || pend[1]);
    endtask

    task automatic forward_pair(int w);
        issue(w, 0, 5, 1, 2, 2 + C, "R7 producer");
        do @(negedge clk); while (!(done && done_warp == w[0]));
        iss_warp = w[0];
        #1;
        chk(iss_ready, "R5 ready high in final beat cycle", 32'(iss_ready), 1);
        issue(w, 3, 7, 5, 5, 2 + C, "R7 forwarded read");
        wait_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            pend[w] = 0; beat[w] = 0; lat[w] = 0; tag[w] = "";
            for (int r = 0; r < NR; r++)
                for (int l = 0; l < WS; l++) mdl[w][r][l] = seed_m(w, r, l);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        for (int w = 0; w < NW; w++) begin
            iss_warp = w[0];
            #1;
            chk(iss_ready, "R1 ready after reset", 32'(iss_ready), 1);
        end
        chk(!wb_valid, "R1 wb_valid low after reset", 32'(wb_valid), 0);
        chk(!done, "R1 done low after reset", 32'(done), 0);

        // R1: reset contents of every register, copied through OR r,r,r
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++) begin
                @(negedge clk);
                issue(w, 3, r, r, r, 2 + C, "R1 reset contents");
                wait_idle();
            end

        // R2: every opcode on varied register triples, both warps
        for (int w = 0; w < NW; w++)
            for (int op = 0; op < 4; op++)
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    issue(w, op, (k*3 + op) % NR, (k + op) % NR, (k*5 + 1) % NR, 2 + C, "R2 op result");
                    wait_idle();
                end

        // R8: warp 0 write then read the same register number in warp 1
        @(negedge clk);
        issue(0, 0, 3, 1, 2, 2 + C, "R8 warp0 write");
        wait_idle();
        @(negedge clk);
        issue(1, 3, 3, 3, 3, 2 + C, "R8 bank isolation");
        wait_idle();

        // R5/R6: overlap in both orders
        for (int first = 0; first < NW; first++) begin
            @(negedge clk);
            issue(first, 1, 4, 5, 6, 2 + C, "R6 holder");
            @(negedge clk);
            issue(1 - first, 0, 6, 4, 7, 1 + 2*C, "R6 waiting warp");
            chk(acc[1 - first] - acc[first] == 1, "R5 other warp accepted while busy",
                32'(acc[1 - first] - acc[first]), 1);
            wait_idle();
        end

        // R7: dependent issue in the producer's final beat cycle
        for (int w = 0; w < NW; w++) begin
            @(negedge clk);
            forward_pair(w);
        end

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule